// File: doc/BRIEF.md
# Multiword DMA Write Strobe Sequencer

This block is the host-side engine for one direction of a multiword DMA exchange with an ATA-style storage device: host to device. While software has a transfer pending and the device requests service, the sequencer raises its acknowledge. It then clocks 16-bit words out to the device, one per strobe. Each write strobe is an active-low pulse whose low width and high width come from counts that software programs.

Every interval is a count of host clock periods. These intervals are the setup from acknowledge to the first strobe, the strobe low width, the strobe high width, and a tail hold. The tail hold is the larger of two counts. The data buffer enable follows acknowledge with its own turn-on and turn-off delays. Words arrive from the host through a valid/ready handshake. A missing word stretches the strobe-high phase and never produces a short or empty pulse.

A burst ends after the programmed number of words, or sooner if the device drops its request. A strobe that has started always runs its full low width. The timing counts and the word count are captured when the burst starts.

Top module: `mdma_wr_sequencer`

## Requirements
- R1: In idle, with `xfer_go`=1, `dev_req`=1 and `xfer_words`≠0, `dev_ack` rises one cycle later. No burst starts while `dev_req`=0 or `xfer_words`=0.
- R2: `strobe_n` first falls `cfg_setup` cycles after `dev_ack` rises, provided a word is valid.
- R3: Each `strobe_n` low window lasts `cfg_active` cycles.
- R4: Between two strobes, `strobe_n` stays high for `cfg_recover` cycles. The first high window after the first strobe is shortened by two cycles, to max(`cfg_recover`−2, 1). A full word cycle therefore lasts `cfg_active`+`cfg_recover`.
- R5: `wdata_out` carries the word accepted in the handshake (the cycle where `wr_valid` and `wr_ready` are both 1). It holds that word for the whole low window. Words go out in acceptance order.
- R6: When no word is valid at the end of a high window, `strobe_n` stays high and `dev_ack` stays high until a word arrives. The strobe then falls one cycle after acceptance.
- R7: A burst with `dev_req` held high produces exactly `xfer_words` strobes.
- R8: `dev_req` is sampled in the last cycle of each low window. If it is 0 there, that strobe completes and the burst ends.
- R9: After the last strobe rises, `dev_ack` falls max(`cfg_recover`, `cfg_hold`) cycles later.
- R10: `buf_en` rises `cfg_buf_on` cycles after `dev_ack` rises. It falls `cfg_buf_off` cycles after `dev_ack` falls.
- R11: A timing count of 0 acts as 1 cycle.
- R12: Timing inputs written during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_go | input | 1 | Transfer pending (level) |
| xfer_words | input | WCW | Words in the burst |
| cfg_setup | input | TW | Acknowledge-to-first-strobe cycles |
| cfg_active | input | TW | Strobe low width |
| cfg_recover | input | TW | Strobe high width |
| cfg_hold | input | TW | Minimum tail after last strobe |
| cfg_buf_on | input | TW | Buffer enable turn-on delay |
| cfg_buf_off | input | TW | Buffer enable turn-off delay |
| wr_valid | input | 1 | Host word valid |
| wr_data | input | DW | Host word |
| wr_ready | output | 1 | Sequencer takes the word this cycle |
| dev_req | input | 1 | Device DMA request |
| dev_ack | output | 1 | DMA acknowledge to device |
| strobe_n | output | 1 | Active-low write strobe |
| wdata_out | output | DW | Data to device |
| buf_en | output | 1 | Data output buffer enable |

## Verification
The embedded assertions check these rules on every cycle:
- acknowledge rises only after a request with a transfer pending;
- the strobe is low only under acknowledge;
- the data holds across each low window;
- the handshake opens only in a high phase under acknowledge;
- no strobe starts with the word count spent;
- acknowledge falls only while the strobe is high;
- the buffer enable moves only in line with acknowledge.

Exact interval lengths can only be shown by the bench's timed scenarios. These lengths are the setup delay, the low and high widths, the shortened first high window, the tail hold, the buffer delays, and the clamping of zero counts. The same holds for the early stop on a dropped request, host stalls, and mid-burst rewrites of the timing inputs.

// File: rtl/mdma_wr_pkg.sv
package mdma_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_RELEASE
    } seq_state_e;

    // A programmed count of zero still lasts one cycle.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Count reduced by cut, never below one cycle.
    function automatic int unsigned shortened(input int unsigned v, input int unsigned cut);
        return (v > cut) ? (v - cut) : 1;
    endfunction

endpackage

// File: rtl/mdma_wr_phase_timer.sv
module mdma_wr_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    // done marks the final cycle of the loaded interval; the count rests at one.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(1);
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(1));

    assert_timer_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);
endmodule

// File: rtl/mdma_wr_bufctl.sv
module mdma_wr_bufctl #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic [TW-1:0] on_dly,
    input  logic [TW-1:0] off_dly,
    output logic          buf_en
);
    import mdma_wr_pkg::*;

    typedef struct packed {
        logic          ack_prev;
        logic          en;
        logic [TW-1:0] on_left;
        logic [TW-1:0] off_left;
    } buf_t;

    buf_t r_d, r_q;
    logic rise, fall;
    logic [TW-1:0] on_eff, off_eff;

    assign rise    = ack && !r_q.ack_prev;
    assign fall    = !ack && r_q.ack_prev;
    assign on_eff  = TW'(at_least_one(32'(on_dly)));
    assign off_eff = TW'(at_least_one(32'(off_dly)));

    always_comb begin
        r_d = r_q;
        r_d.ack_prev = ack;
        if (rise) begin
            r_d.off_left = '0;
            if (on_eff == TW'(1)) begin
                r_d.en      = 1'b1;
                r_d.on_left = '0;
            end else begin
                r_d.on_left = on_eff - TW'(1);
            end
        end else if (fall) begin
            r_d.on_left = '0;
            if (off_eff == TW'(1)) begin
                r_d.en       = 1'b0;
                r_d.off_left = '0;
            end else begin
                r_d.off_left = off_eff - TW'(1);
            end
        end else begin
            if (r_q.on_left != '0) begin
                r_d.on_left = r_q.on_left - TW'(1);
                if (r_q.on_left == TW'(1)) r_d.en = 1'b1;
            end
            if (r_q.off_left != '0) begin
                r_d.off_left = r_q.off_left - TW'(1);
                if (r_q.off_left == TW'(1)) r_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign buf_en = r_q.en;

    assert_buf_on_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_en) |-> $past(ack));
    assert_buf_off_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_en) |-> !$past(ack));
endmodule

// File: rtl/mdma_wr_sequencer.sv
module mdma_wr_sequencer #(
    parameter int DW  = 16,
    parameter int TW  = 8,
    parameter int WCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xfer_go,
    input  logic [WCW-1:0] xfer_words,
    input  logic [TW-1:0]  cfg_setup,
    input  logic [TW-1:0]  cfg_active,
    input  logic [TW-1:0]  cfg_recover,
    input  logic [TW-1:0]  cfg_hold,
    input  logic [TW-1:0]  cfg_buf_on,
    input  logic [TW-1:0]  cfg_buf_off,
    input  logic           wr_valid,
    input  logic [DW-1:0]  wr_data,
    output logic           wr_ready,
    input  logic           dev_req,
    output logic           dev_ack,
    output logic           strobe_n,
    output logic [DW-1:0]  wdata_out,
    output logic           buf_en
);
    import mdma_wr_pkg::*;

    localparam int FIRST_CUT = 2;

    typedef struct packed {
        logic [TW-1:0] setup;
        logic [TW-1:0] active;
        logic [TW-1:0] recover;
        logic [TW-1:0] hold;
        logic [TW-1:0] buf_on;
        logic [TW-1:0] buf_off;
    } cfg_t;

    typedef struct packed {
        seq_state_e     state;
        cfg_t           cfg;
        logic [WCW-1:0] rem;
        logic [DW-1:0]  data;
        logic           ack;
        logic           strobe_n;
        logic           first;
    } seq_t;

    seq_t r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          ready_c;
    cfg_t          cfg_in;

    assign cfg_in = '{setup: cfg_setup, active: cfg_active, recover: cfg_recover,
                      hold: cfg_hold, buf_on: cfg_buf_on, buf_off: cfg_buf_off};

    mdma_wr_phase_timer #(.CW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = TW'(1);
        ready_c  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (xfer_go && dev_req && (xfer_words != '0)) begin
                    r_d.cfg   = cfg_in;
                    r_d.rem   = xfer_words;
                    r_d.ack   = 1'b1;
                    r_d.first = 1'b1;
                    r_d.state = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(at_least_one(32'(cfg_setup)));
                end
            end
            ST_SETUP, ST_RECOVER: begin
                if (tmr_done) begin
                    ready_c = 1'b1;
                    if (wr_valid) begin
                        r_d.data     = wr_data;
                        r_d.strobe_n = 1'b0;
                        r_d.state    = ST_ACTIVE;
                        tmr_load     = 1'b1;
                        tmr_val      = TW'(at_least_one(32'(r_q.cfg.active)));
                    end
                end
            end
            ST_ACTIVE: begin
                if (tmr_done) begin
                    r_d.strobe_n = 1'b1;
                    r_d.rem      = r_q.rem - WCW'(1);
                    tmr_load     = 1'b1;
                    if ((r_q.rem == WCW'(1)) || !dev_req) begin
                        r_d.state = ST_RELEASE;
                        tmr_val   = TW'(at_least_one(larger(32'(r_q.cfg.recover),
                                                           32'(r_q.cfg.hold))));
                    end else begin
                        r_d.state = ST_RECOVER;
                        r_d.first = 1'b0;
                        if (r_q.first)
                            tmr_val = TW'(shortened(32'(r_q.cfg.recover), FIRST_CUT));
                        else
                            tmr_val = TW'(at_least_one(32'(r_q.cfg.recover)));
                    end
                end
            end
            ST_RELEASE: begin
                if (tmr_done) begin
                    r_d.ack   = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.strobe_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    mdma_wr_bufctl #(.TW(TW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (r_q.ack),
        .on_dly  (r_q.cfg.buf_on),
        .off_dly (r_q.cfg.buf_off),
        .buf_en  (buf_en)
    );

    assign wr_ready  = ready_c;
    assign dev_ack   = r_q.ack;
    assign strobe_n  = r_q.strobe_n;
    assign wdata_out = r_q.data;

    assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> ($past(dev_req) && $past(xfer_go)));
    assert_strobe_under_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> dev_ack);
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !$past(strobe_n)) |-> $stable(wdata_out));
    assert_ready_in_high_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (dev_ack && strobe_n));
    assert_no_strobe_past_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> ($past(r_q.rem) != '0));
    assert_release_strobe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ack) |-> (strobe_n && $past(strobe_n)));
endmodule

// File: tb/tb_mdma_wr_sequencer.sv
module tb_mdma_wr_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_go = 1'b0;
    logic [15:0] xfer_words = '0;
    logic [7:0]  cfg_setup = '0, cfg_active = '0, cfg_recover = '0;
    logic [7:0]  cfg_hold = '0, cfg_buf_on = '0, cfg_buf_off = '0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic        dev_req = 1'b0;
    logic        dev_ack, strobe_n, buf_en;
    logic [15:0] wdata_out;

    mdma_wr_sequencer dut (
        .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_words(xfer_words),
        .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_recover(cfg_recover),
        .cfg_hold(cfg_hold), .cfg_buf_on(cfg_buf_on), .cfg_buf_off(cfg_buf_off),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .dev_req(dev_req), .dev_ack(dev_ack), .strobe_n(strobe_n),
        .wdata_out(wdata_out), .buf_en(buf_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int fall_t[$], rise_t[$];
    int ack_rise_t = -1, ack_fall_t = -1, buf_rise_t = -1, buf_fall_t = -1;
    logic [15:0] host_q[$], exp_q[$];
    logic [15:0] held_word = '0;
    int  gap_set = 0, gap_left = 0;
    bit  take = 0;
    logic prev_s = 1'b1, prev_a = 1'b0, prev_b = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cl(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Monitor / scoreboard: sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_s && !strobe_n) begin
                fall_t.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check(0, "R7", "strobe with no expected word", 1, 0);
                end else begin
                    held_word = exp_q.pop_front();
                    check(wdata_out == held_word, "R5", "word at strobe", wdata_out, held_word);
                end
            end else if (!strobe_n && wdata_out != held_word) begin
                check(0, "R5", "word held in low window", wdata_out, held_word);
            end
            if (!prev_s && strobe_n) rise_t.push_back(cyc);
            if (!prev_a && dev_ack) ack_rise_t = cyc;
            if (prev_a && !dev_ack) ack_fall_t = cyc;
            if (!prev_b && buf_en) buf_rise_t = cyc;
            if (prev_b && !buf_en) buf_fall_t = cyc;
        end
        prev_s = strobe_n;
        prev_a = dev_ack;
        prev_b = buf_en;
    end

    // Host-side word driver.
    always @(negedge clk) begin
        if (take) begin
            void'(host_q.pop_front());
            gap_left = gap_set;
        end else if (gap_left > 0) begin
            gap_left--;
        end
        wr_valid = (host_q.size() != 0) && (gap_left == 0);
        wr_data  = wr_valid ? host_q[0] : 16'h0;
        take     = wr_valid && wr_ready;
    end

    always @(negedge clk) begin
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d expected < %0d", cyc, WATCHDOG);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_burst(input int m, input int d, input int k, input int jn,
                             input int on, input int off, input int words,
                             input bit drop, input bit scramble, input int gap,
                             input int seed);
        int go_t, nexp;
        fall_t.delete();
        rise_t.delete();
        ack_rise_t = -1; ack_fall_t = -1; buf_rise_t = -1; buf_fall_t = -1;
        for (int i = 0; i < words; i++) begin
            logic [15:0] w;
            w = 16'(seed * 4099 + i * 16'h0131) ^ 16'hA55A;
            host_q.push_back(w);
            exp_q.push_back(w);
        end
        cfg_setup = 8'(m); cfg_active = 8'(d); cfg_recover = 8'(k);
        cfg_hold = 8'(jn); cfg_buf_on = 8'(on); cfg_buf_off = 8'(off);
        gap_set = gap;
        dev_req = 1'b1;
        xfer_words = 16'(words);
        tick(1);
        xfer_go = 1'b1;
        go_t = cyc;
        while (!dev_ack) tick(1);
        xfer_go = 1'b0;
        if (scramble) begin
            cfg_setup = 8'd9; cfg_active = 8'd9; cfg_recover = 8'd9;
            cfg_hold = 8'd9; cfg_buf_on = 8'd9; cfg_buf_off = 8'd9;
        end
        while (dev_ack) begin
            tick(1);
            if (drop && fall_t.size() == 2) dev_req = 1'b0;
        end
        tick(cl(off) + 4);

        nexp = drop ? 2 : words;
        check(ack_rise_t - go_t == 1, "R1", "ack delay after go", ack_rise_t - go_t, 1);
        check(fall_t.size() == nexp, drop ? "R8" : "R7", "strobe count", fall_t.size(), nexp);
        check(rise_t.size() == fall_t.size(), "R8", "strobe completed", rise_t.size(), fall_t.size());
        if (fall_t.size() == nexp && rise_t.size() == nexp) begin
            check(fall_t[0] - ack_rise_t == cl(m), scramble ? "R12" : "R2",
                  "setup", fall_t[0] - ack_rise_t, cl(m));
            for (int i = 0; i < nexp; i++)
                check(rise_t[i] - fall_t[i] == cl(d), scramble ? "R12" : "R3",
                      "low width", rise_t[i] - fall_t[i], cl(d));
            for (int i = 0; i + 1 < nexp; i++) begin
                int hexp;
                if (gap > 0) hexp = gap + 1 - cl(d);
                else if (i == 0) hexp = (k > 2) ? k - 2 : 1;
                else hexp = cl(k);
                check(fall_t[i+1] - rise_t[i] == hexp, gap > 0 ? "R6" : "R4",
                      "high width", fall_t[i+1] - rise_t[i], hexp);
            end
            check(ack_fall_t - rise_t[nexp-1] == cl((k > jn) ? k : jn), "R9",
                  "ack tail", ack_fall_t - rise_t[nexp-1], cl((k > jn) ? k : jn));
        end
        check(buf_rise_t - ack_rise_t == cl(on), "R10", "buf on delay",
              buf_rise_t - ack_rise_t, cl(on));
        check(buf_fall_t - ack_fall_t == cl(off), "R10", "buf off delay",
              buf_fall_t - ack_fall_t, cl(off));
        check(exp_q.size() == words - nexp, "R5", "words left unsent", exp_q.size(), words - nexp);
        host_q.delete();
        exp_q.delete();
        gap_set = 0;
        dev_req = 1'b0;
        tick(3);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(dev_ack == 1'b0, "R1", "reset ack", dev_ack, 0);
        check(strobe_n == 1'b1, "R3", "reset strobe", strobe_n, 1);
        check(buf_en == 1'b0, "R10", "reset buf_en", buf_en, 0);
        check(wr_ready == 1'b0, "R5", "reset ready", wr_ready, 0);

        // R1: no start without words, nor without device request.
        xfer_go = 1'b1; dev_req = 1'b1; xfer_words = '0;
        tick(6);
        check(dev_ack == 1'b0, "R1", "ack with zero words", dev_ack, 0);
        dev_req = 1'b0; xfer_words = 16'd3;
        tick(6);
        check(dev_ack == 1'b0, "R1", "ack without request", dev_ack, 0);
        xfer_go = 1'b0;
        tick(2);

        run_burst(3, 2, 4, 2, 2, 3, 4, 0, 0, 0, 1);  // R2 R3 R4 R7 R9 R10
        run_burst(0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 2);  // R11 all counts clamp to one
        run_burst(1, 4, 2, 6, 1, 1, 5, 1, 0, 0, 3);  // R8 early stop, hold dominates
        run_burst(5, 3, 5, 1, 4, 2, 3, 0, 1, 0, 4);  // R12 rewrites ignored
        run_burst(2, 2, 3, 1, 1, 1, 3, 0, 0, 8, 5);  // R6 host stall
        run_burst(2, 3, 7, 2, 3, 5, 1, 0, 0, 0, 6);  // R7 single word

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule